// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block supervises software with an absolute deadline rather than a countdown. A free-running system count arrives on an input bus. Software programs an offset period, and a refresh sets the deadline to the present count plus that period. While the watchdog is enabled and the count reaches the deadline, the block escalates in two steps.

The first expiry raises a warning flag that drives an interrupt line, and it pushes the deadline out by one more offset period. If the count reaches that new deadline before any refresh arrives, the block raises a trip flag and holds a reset request for the reset controller. The trip flag outlives the system reset that it causes. Only the power-on reset clears it, so software can find out after boot that the watchdog caused the last reset.

Registers sit in two frames on one simple bus, with writes handled in one cycle and combinational reads. A frame-select bit picks the frame. The control frame holds the enable and status word, the offset, the two halves of the deadline and a fixed interface identifier. The refresh frame holds one refresh location.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset (`rst`), the control word at control offset 0x000 reads 0, `irq_o` and `reset_req_o` are low, the offset at 0x008 reads 0, and the identifier at 0xFCC reads the `IFACE_ID` parameter.
- R2: A write to control offset 0x008 stores the offset, which reads back zero-extended at 0x008. The same write sets the deadline to the count sampled at that edge plus the written offset, and it clears the warning flag.
- R3: A write of any data to refresh-frame offset 0x000 sets the deadline to the current count plus the stored offset and clears the warning flag.
- R4: Writes to control offset 0x010 replace the low word of the deadline, and writes to 0x014 replace the high word. Either write clears the warning flag, and both halves read back at the same offsets.
- R5: The control word at 0x000 has bit 0 = enable, bit 1 = warning flag and bit 2 = trip flag. A write to it changes only the enable bit; bits 1 and 2 of the written data have no effect.
- R6: While enabled, with the warning flag clear, a clock edge at which the count is greater than or equal to the deadline sets the warning flag, raises `irq_o` from the next cycle on, and reloads the deadline with count plus offset.
- R7: While enabled, with the warning flag set, a clock edge at which the count reaches the deadline sets the trip flag and raises `reset_req_o`. With refreshes absent, the trip therefore follows the warning by exactly one offset period.
- R8: While disabled, both flags and the deadline are frozen, whatever the count does.
- R9: `soft_rst` clears the enable, the warning flag, the offset and the deadline. It leaves the trip flag and `reset_req_o` unchanged. Only `rst` clears those two.
- R10: If a deadline-setting write (offset, either deadline half or refresh) lands on the same edge as an expiry, the write takes effect and the expiry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; clears everything |
| soft_rst | input | 1 | Synchronous active-high system reset; keeps trip flag |
| count_i | input | 2*DATA_W | Free-running system count |
| bus_valid | input | 1 | Bus access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | ADDR_W | Byte offset within the frame |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Warning-stage interrupt |
| reset_req_o | output | 1 | Trip-stage reset request |

## Verification
The bench builds the block with DATA_W = 16 and a 32-bit count. A deadline that crosses from the low half into the high half then takes only a few counts to reach, and the two half-word writes can be tested separately. The identifier parameter is overridden to a non-default value. For each offset from 1 to 6, the bench steps the count one tick at a time from a refresh and predicts the exact edge of the warning and of the trip. Separate directed sequences cover refresh during the warning stage, a write that collides with an expiry, freezing while disabled, and a system reset that the trip flag survives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Byte offsets inside the control frame
    localparam int unsigned OFS_CTRL   = 'h000;
    localparam int unsigned OFS_PERIOD = 'h008;
    localparam int unsigned OFS_DL_LO  = 'h010;
    localparam int unsigned OFS_DL_HI  = 'h014;
    localparam int unsigned OFS_IDENT  = 'hFCC;
    // Byte offset inside the refresh frame
    localparam int unsigned OFS_KICK   = 'h000;

    // One-cycle write strobes produced by the decoder
    typedef struct packed {
        logic ctrl_wr;
        logic period_wr;
        logic dl_lo_wr;
        logic dl_hi_wr;
        logic kick;
    } wr_strobe_t;

    // Control word bits, LSB = enable
    typedef struct packed {
        logic trip;
        logic warn;
        logic en;
    } ctrl_bits_t;

    // Action taken by the deadline comparator on a given edge
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_WARN = 2'd1,
        ACT_TRIP = 2'd2
    } expiry_act_e;

    function automatic logic deadline_touch(input wr_strobe_t s);
        return s.period_wr | s.dl_lo_wr | s.dl_hi_wr | s.kick;
    endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic                    bus_frame,
    input  logic [ADDR_W-1:0]       bus_addr,
    output wdt_pkg::wr_strobe_t     strobe
);
    import wdt_pkg::*;

    logic wr_ctl;
    logic wr_rfr;

    assign wr_ctl = bus_valid & bus_write & ~bus_frame;
    assign wr_rfr = bus_valid & bus_write &  bus_frame;

    always_comb begin
        strobe           = '0;
        strobe.ctrl_wr   = wr_ctl && (bus_addr == ADDR_W'(OFS_CTRL));
        strobe.period_wr = wr_ctl && (bus_addr == ADDR_W'(OFS_PERIOD));
        strobe.dl_lo_wr  = wr_ctl && (bus_addr == ADDR_W'(OFS_DL_LO));
        strobe.dl_hi_wr  = wr_ctl && (bus_addr == ADDR_W'(OFS_DL_HI));
        strobe.kick      = wr_rfr && (bus_addr == ADDR_W'(OFS_KICK));
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic [CNT_W-1:0]    count_i,
    input  wdt_pkg::wr_strobe_t strobe,
    input  logic [DATA_W-1:0]   wdata,
    output wdt_pkg::ctrl_bits_t flags,
    output logic [DATA_W-1:0]   period,
    output logic [CNT_W-1:0]    deadline
);
    import wdt_pkg::*;

    logic               en_q;
    logic               warn_q;
    logic               trip_q;
    logic [DATA_W-1:0]  period_q;
    logic [CNT_W-1:0]   dl_q;
    logic [CNT_W-1:0]   next_from_stored;
    logic [CNT_W-1:0]   next_from_wdata;
    logic               dl_wr;
    expiry_act_e        act;

    assign next_from_stored = count_i + {{DATA_W{1'b0}}, period_q};
    assign next_from_wdata  = count_i + {{DATA_W{1'b0}}, wdata};
    assign dl_wr            = deadline_touch(strobe);

    // Comparator: a bus write that moves the deadline wins over expiry
    always_comb begin
        act = ACT_NONE;
        if (en_q && !dl_wr && (count_i >= dl_q))
            act = warn_q ? ACT_TRIP : ACT_WARN;
    end

    // Enable, warning flag, period and deadline: cleared by either reset
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            en_q     <= 1'b0;
            warn_q   <= 1'b0;
            period_q <= '0;
            dl_q     <= '0;
        end else begin
            if (strobe.ctrl_wr)
                en_q <= wdata[0];
            if (strobe.period_wr) begin
                period_q <= wdata;
                dl_q     <= next_from_wdata;
            end
            if (strobe.dl_lo_wr)
                dl_q[DATA_W-1:0] <= wdata;
            if (strobe.dl_hi_wr)
                dl_q[CNT_W-1:DATA_W] <= wdata;
            if (strobe.kick)
                dl_q <= next_from_stored;
            if (dl_wr)
                warn_q <= 1'b0;
            if (act == ACT_WARN) begin
                warn_q <= 1'b1;
                dl_q   <= next_from_stored;
            end
        end
    end

    // Trip flag: survives the system reset it requests
    always_ff @(posedge clk) begin
        if (rst)
            trip_q <= 1'b0;
        else if (!soft_rst && act == ACT_TRIP)
            trip_q <= 1'b1;
    end

    always_comb begin
        flags.en   = en_q;
        flags.warn = warn_q;
        flags.trip = trip_q;
    end
    assign period   = period_q;
    assign deadline = dl_q;

endmodule

// File: rtl/wdt_readmux.sv
module wdt_readmux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12,
    parameter logic [DATA_W-1:0] IFACE_ID = '0,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic                bus_frame,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  wdt_pkg::ctrl_bits_t flags,
    input  logic [DATA_W-1:0]   period,
    input  logic [CNT_W-1:0]    deadline,
    output logic [DATA_W-1:0]   rdata
);
    import wdt_pkg::*;

    always_comb begin
        rdata = '0;
        if (!bus_frame) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))
                rdata = {{(DATA_W-3){1'b0}}, flags};
            else if (bus_addr == ADDR_W'(OFS_PERIOD))
                rdata = period;
            else if (bus_addr == ADDR_W'(OFS_DL_LO))
                rdata = deadline[DATA_W-1:0];
            else if (bus_addr == ADDR_W'(OFS_DL_HI))
                rdata = deadline[CNT_W-1:DATA_W];
            else if (bus_addr == ADDR_W'(OFS_IDENT))
                rdata = IFACE_ID;
        end
    end

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12,
    parameter logic [DATA_W-1:0] IFACE_ID = DATA_W'(32'h5744_0101)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic [2*DATA_W-1:0]   count_i,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_frame,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o,
    output logic                  reset_req_o
);
    import wdt_pkg::*;

    localparam int unsigned CNT_W = 2 * DATA_W;

    wr_strobe_t         strobe;
    ctrl_bits_t         flags;
    logic [DATA_W-1:0]  period;
    logic [CNT_W-1:0]   deadline;
    logic               wd_en;

    wdt_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .strobe    (strobe)
    );

    wdt_core #(.DATA_W(DATA_W)) i_core (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .count_i  (count_i),
        .strobe   (strobe),
        .wdata    (bus_wdata),
        .flags    (flags),
        .period   (period),
        .deadline (deadline)
    );

    wdt_readmux #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .IFACE_ID (IFACE_ID)
    ) i_readmux (
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .flags     (flags),
        .period    (period),
        .deadline  (deadline),
        .rdata     (bus_rdata)
    );

    assign wd_en       = flags.en;
    assign irq_o       = flags.warn;
    assign reset_req_o = flags.trip;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_frame,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              en_q,
    input logic              irq_o,
    input logic              reset_req_o
);

    // R7
    trip_after_warn_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req_o) |-> $past(irq_o));

    // R9
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req_o |=> reset_req_o);

    // R8
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !bus_valid && !soft_rst) |=> ($stable(irq_o) && $stable(reset_req_o)));

    // R3
    kick_clears_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_frame && bus_addr == '0) |=> !irq_o);

    // R6
    warn_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(en_q));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_frame   (bus_frame),
    .bus_addr    (bus_addr),
    .en_q        (wd_en),
    .irq_o       (irq_o),
    .reset_req_o (reset_req_o)
);

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;

    localparam int unsigned DW = 16;
    localparam int unsigned AW = 12;
    localparam int unsigned CW = 2 * DW;
    localparam logic [DW-1:0] ID = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic          bus_frame = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;
    logic          reset_req_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdt_two_stage #(.DATA_W(DW), .ADDR_W(AW), .IFACE_ID(ID)) i_wdt_two_stage (
        .clk (clk), .rst (rst), .soft_rst (soft_rst), .count_i (count_i),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_frame (bus_frame),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_o (irq_o), .reset_req_o (reset_req_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic frame, input int unsigned addr, input logic [DW-1:0] data);
        bus_valid = 1'b1; bus_write = 1'b1; bus_frame = frame;
        bus_addr = AW'(addr); bus_wdata = data;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic frame, input int unsigned addr, output logic [DW-1:0] data);
        bus_frame = frame; bus_addr = AW'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic por;
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        logic [CW-1:0] base;
        por();
        // R1 reset state
        rd(0, 'h000, r); chk("R1 ctrl", r, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 reset_req", reset_req_o, 0);
        rd(0, 'hFCC, r); chk("R1 ident", r, ID);
        rd(0, 'h008, r); chk("R1 offset", r, 0);

        // R2 offset write, deadline crosses into the high half
        count_i = 32'h0000_FFFE;
        wr(0, 'h008, 16'd5);
        rd(0, 'h008, r); chk("R2 offset readback", r, 5);
        rd(0, 'h010, r); chk("R2 deadline lo", r, 16'h0003);
        rd(0, 'h014, r); chk("R2 deadline hi", r, 16'h0001);

        // R4 direct deadline halves
        wr(0, 'h010, 16'h1234);
        rd(0, 'h010, r); chk("R4 lo write", r, 16'h1234);
        rd(0, 'h014, r); chk("R4 hi kept", r, 16'h0001);
        wr(0, 'h014, 16'h0007);
        rd(0, 'h014, r); chk("R4 hi write", r, 16'h0007);

        // R8 disabled: far past the deadline, nothing happens
        count_i = 32'hFFFF_FFFF;
        tick(); tick(); tick();
        chk("R8 irq frozen", irq_o, 0);
        rd(0, 'h010, r); chk("R8 deadline frozen", r, 16'h1234);

        // R5 flag bits in written data are ignored
        wr(0, 'h000, 16'h0006);
        rd(0, 'h000, r); chk("R5 flag bits ignored", r, 0);

        // R6 / R7 sweep over offsets
        for (int ofs = 1; ofs <= 6; ofs++) begin
            por();
            base = CW'(1000 + ofs * 50);
            count_i = base;
            wr(0, 'h008, DW'(ofs));
            wr(0, 'h000, 16'h0001);
            wr(1, 'h000, 16'hBEEF); // R3 arbitrary data
            rd(0, 'h000, r); chk("R5 enable readback", r, 1);
            for (int k = 1; k <= 2 * ofs + 1; k++) begin
                count_i = base + CW'(k);
                tick();
                chk("R6 warn edge", irq_o, (k >= ofs) ? 1 : 0);
                chk("R7 trip edge", reset_req_o, (k >= 2 * ofs) ? 1 : 0);
                if (k == ofs) begin
                    rd(0, 'h010, r);
                    chk("R6 reload", r, DW'(base + CW'(2 * ofs)));
                end
            end
            rd(0, 'h000, r); chk("R5 both flags", r, 7);
        end

        // R9 system reset keeps the trip flag
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        rd(0, 'h000, r); chk("R9 ctrl after soft reset", r, 4);
        chk("R9 reset_req kept", reset_req_o, 1);
        chk("R9 irq cleared", irq_o, 0);
        rd(0, 'h008, r); chk("R9 offset cleared", r, 0);
        por();
        chk("R9 por clears trip", reset_req_o, 0);

        // R3 refresh during warning stage
        count_i = 100;
        wr(0, 'h008, 16'd4);
        wr(0, 'h000, 16'h0001);
        count_i = 104; tick();
        chk("R6 warn", irq_o, 1);
        count_i = 106;
        wr(1, 'h000, 16'h0000);
        chk("R3 refresh clears warn", irq_o, 0);
        rd(0, 'h010, r); chk("R3 new deadline", r, 110);
        count_i = 109; tick();
        chk("R3 no early warn", irq_o, 0);
        count_i = 110; tick();
        chk("R3 warn at new deadline", irq_o, 1);
        chk("R3 no trip", reset_req_o, 0);

        // R10 refresh on the expiry edge wins
        count_i = 114;
        wr(1, 'h000, 16'h1111);
        chk("R10 no trip", reset_req_o, 0);
        chk("R10 warn cleared", irq_o, 0);
        rd(0, 'h010, r); chk("R10 deadline", r, 118);

        // R8 disable freezes, re-enable resumes
        wr(0, 'h000, 16'h0000);
        count_i = 200; tick(); tick();
        chk("R8 irq off", irq_o, 0);
        rd(0, 'h010, r); chk("R8 deadline held", r, 118);
        wr(0, 'h000, 16'h0001);
        tick();
        chk("R8 resumes", irq_o, 1);

        // R2 offset write clears warning
        wr(0, 'h008, 16'd3);
        chk("R2 warn cleared", irq_o, 0);
        rd(0, 'h010, r); chk("R2 deadline", r, 203);

        // R4 direct deadline write clears warning
        count_i = 203; tick();
        chk("R6 warn again", irq_o, 1);
        wr(0, 'h010, 16'd500);
        chk("R4 warn cleared", irq_o, 0);
        rd(0, 'h010, r); chk("R4 deadline", r, 500);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule